// File: doc/BRIEF.md
# Data Memory Access Unit

This block sits between a processor core's execute stage and its data bus. The core hands it one load or store at a time: an address, an access size, a flag that selects sign or zero extension, and store data. The unit checks the alignment of the access before anything reaches the bus. An access it can already tell will trap is finished locally with the matching cause code, so the bus never sees it.

For accesses that pass the check, the unit drives a request beat over a valid/ready channel. For stores it places the data in the byte lanes that the address selects and marks them with a write strobe. It then waits for the response beat on a separate valid/ready channel. It shifts the returned word down to the addressed lane and extends it to the full register width. The bus returns a single error bit, and the unit turns it into a load fault code or a store fault code, because it knows which kind of access it issued. Every transaction ends in a one-cycle completion pulse. The pulse carries either a load result or a cause code together with the faulting address.

Top module: `dmem_access_unit`

## Requirements
- R1: Access sizes are encoded 00 = byte, 01 = halfword, 10 = word. A halfword with address bit 0 set, a word with either of address bits 1:0 set, and any access with the reserved size 11 are misaligned. For these the unit never raises `bus_req_valid`, and it pulses `cpu_done` with `cpu_fault` in the cycle after acceptance.
- R2: A misaligned load reports `cpu_cause` = 4 and a misaligned store reports `cpu_cause` = 6. In both cases `cpu_tval` equals the requested address.
- R3: A store drives the strobe `bus_req_wstrb` = 0001 shifted left by addr[1:0] for a byte, 0011 shifted left by addr[1:0] for a halfword, and 1111 for a word. The low 8, 16 or 32 bits of the store data are shifted left by 8 × addr[1:0] into `bus_req_wdata`, and the lanes that are not written are zero.
- R4: A load request drives `bus_req_we` = 0, `bus_req_wstrb` = 0000 and `bus_req_wdata` = 0. Every request drives `bus_req_amo` = 0. `bus_req_addr` and `bus_req_size` are copied from the CPU request.
- R5: A successful load returns the response word shifted right by 8 × addr[1:0]. Byte and halfword results are sign-extended when `cpu_req_unsigned` = 0 and zero-extended when it is 1. A word is returned unchanged. The result appears on `cpu_load_data` with `cpu_load_wr` = 1.
- R6: A response with `bus_rsp_err` = 1 reports cause 5 for a load and cause 7 for a store, with `cpu_tval` set to the address. `cpu_load_wr` stays 0 on every fault.
- R7: Once raised, `bus_req_valid` and the request fields stay unchanged until `bus_req_ready` is seen. `bus_rsp_ready` is high only after the request beat has been accepted.
- R8: Only one transaction is outstanding at a time. After an aligned request is accepted, `cpu_busy` = 1 and `cpu_req_ready` = 0 until the response beat. After a misaligned request, the unit is ready again in the next cycle.
- R9: After reset `cpu_req_ready` = 1, and `cpu_busy`, `cpu_done` and `bus_req_valid` are 0.
- R10: `cpu_done` pulses for one cycle in the cycle after the response handshake. A successful store completes with `cpu_fault` = 0 and `cpu_load_wr` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_req_valid | input | 1 | Core presents an access |
| cpu_req_ready | output | 1 | Unit can accept an access |
| cpu_req_store | input | 1 | 1 = store, 0 = load |
| cpu_req_size | input | 2 | Access size code |
| cpu_req_unsigned | input | 1 | Zero-extend sub-word load results |
| cpu_req_addr | input | ADDR_W | Byte address |
| cpu_req_wdata | input | 32 | Store data, right-aligned |
| cpu_busy | output | 1 | A bus transaction is in flight |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_fault | output | 1 | Completion is a trap |
| cpu_cause | output | 5 | Architectural cause code on a fault |
| cpu_tval | output | ADDR_W | Faulting address |
| cpu_load_wr | output | 1 | Write cpu_load_data to the register file |
| cpu_load_data | output | 32 | Aligned and extended load result |
| bus_req_valid | output | 1 | Request beat valid |
| bus_req_ready | input | 1 | Bus accepts the request beat |
| bus_req_addr | output | ADDR_W | Request address |
| bus_req_we | output | 1 | 1 = write |
| bus_req_size | output | 2 | Request size code |
| bus_req_wdata | output | 32 | Lane-placed write data |
| bus_req_wstrb | output | 4 | Byte-lane write strobes |
| bus_req_amo | output | 4 | Atomic operation code, always zero |
| bus_rsp_valid | input | 1 | Response beat valid |
| bus_rsp_ready | output | 1 | Unit accepts the response beat |
| bus_rsp_rdata | input | 32 | Read data |
| bus_rsp_err | input | 1 | Slave-reported access fault |

## Verification
The bench builds the unit with its default ADDR_W of 32. This lets the fault address reported on a trap be compared across the full word, including high address bits. The bench's bus model takes a separate request-ready delay and response delay for each transaction. This reaches zero-wait back-to-back beats, long stalls while the request is held, and an error raised after a delay. Misaligned accesses placed directly before aligned ones show that a local fault frees the unit in the very next cycle.

// File: rtl/dau_pkg.sv
`timescale 1ns/1ps
// dau_pkg: shared constants and types for the data memory access unit.
// Assumes a 32-bit data path split into byte lanes.
package dau_pkg;
    localparam int XLEN    = 32;
    localparam int LANES   = XLEN / 8;
    localparam int OFF_W   = $clog2(LANES);
    localparam int CAUSE_W = 5;
    localparam int AMO_W   = 4;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

    localparam logic [CAUSE_W-1:0] CAUSE_LD_MISALIGN = CAUSE_W'(4);
    localparam logic [CAUSE_W-1:0] CAUSE_LD_FAULT    = CAUSE_W'(5);
    localparam logic [CAUSE_W-1:0] CAUSE_ST_MISALIGN = CAUSE_W'(6);
    localparam logic [CAUSE_W-1:0] CAUSE_ST_FAULT    = CAUSE_W'(7);

    typedef struct packed {
        logic      store;
        acc_size_e size;
        logic      unsgn;
    } acc_kind_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_ISSUE = 2'b01,
        ST_WAIT  = 2'b10
    } dau_state_e;
endpackage

// File: rtl/dau_align_check.sv
`timescale 1ns/1ps
// dau_align_check: flags an access whose low address bits do not fit its
// size. Assumes the reserved size code is never legal.
module dau_align_check
    import dau_pkg::*;
(
    input  acc_size_e        size,
    input  logic [OFF_W-1:0] off,
    output logic             misaligned
);
    logic [OFF_W-1:0] must_be_zero;

    // Pick the low-address bits that the size requires to be clear.
    always_comb begin
        must_be_zero = '0;
        misaligned   = 1'b0;
        case (size)
            SZ_BYTE: must_be_zero = '0;
            SZ_HALF: must_be_zero = OFF_W'(1);
            SZ_WORD: must_be_zero = '1;
            default: misaligned   = 1'b1;
        endcase
        if ((off & must_be_zero) != '0) begin
            misaligned = 1'b1;
        end
    end
endmodule

// File: rtl/dau_store_pack.sv
`timescale 1ns/1ps
// dau_store_pack: places right-aligned store data into the addressed byte
// lanes and builds the strobes. Assumes the access is already aligned.
// A read gives zero strobes and zero data.
module dau_store_pack
    import dau_pkg::*;
(
    input  logic             store,
    input  acc_size_e        size,
    input  logic [OFF_W-1:0] off,
    input  logic [XLEN-1:0]  src,
    output logic [LANES-1:0] strb,
    output logic [XLEN-1:0]  lanes
);
    logic [OFF_W:0] nbytes;

    // Number of bytes the access covers.
    always_comb begin
        case (size)
            SZ_BYTE: nbytes = (OFF_W+1)'(1);
            SZ_HALF: nbytes = (OFF_W+1)'(2);
            SZ_WORD: nbytes = (OFF_W+1)'(LANES);
            default: nbytes = '0;
        endcase
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [OFF_W-1:0] src_idx;
        logic             hit;
        // Decide whether lane i is written and which source byte feeds it.
        always_comb begin
            src_idx = OFF_W'(i) - off;
            hit     = store
                   && ((OFF_W+1)'(i) >= {1'b0, off})
                   && ((OFF_W+1)'(i) <  ({1'b0, off} + nbytes));
            strb[i]         = hit;
            lanes[8*i +: 8] = hit ? src[8*src_idx +: 8] : 8'h00;
        end
    end
endmodule

// File: rtl/dau_load_extract.sv
`timescale 1ns/1ps
// dau_load_extract: shifts returned read data down to the addressed lane
// and sign- or zero-extends sub-word results. Assumes an aligned access.
module dau_load_extract
    import dau_pkg::*;
(
    input  logic [XLEN-1:0]  rdata,
    input  acc_size_e        size,
    input  logic             unsgn,
    input  logic [OFF_W-1:0] off,
    output logic [XLEN-1:0]  result
);
    logic [XLEN-1:0] shifted;
    logic            fill;

    // Move the addressed lane to bit 0 and extend it to full width.
    always_comb begin
        shifted = rdata >> (8 * off);
        fill    = 1'b0;
        case (size)
            SZ_BYTE: begin
                fill   = ~unsgn & shifted[7];
                result = {{(XLEN-8){fill}}, shifted[7:0]};
            end
            SZ_HALF: begin
                fill   = ~unsgn & shifted[15];
                result = {{(XLEN-16){fill}}, shifted[15:0]};
            end
            default: result = shifted;
        endcase
    end
endmodule

// File: rtl/dmem_access_unit.sv
`timescale 1ns/1ps
// dmem_access_unit: accepts one load/store at a time from the core.
// Misaligned accesses are finished locally, the rest go over a valid/ready
// request channel. The unit waits for the response and returns either an
// extended load result or a cause code with the faulting address.
// Assumes the response never arrives in the same cycle as its request.
module dmem_access_unit
    import dau_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cpu_req_valid,
    output logic                cpu_req_ready,
    input  logic                cpu_req_store,
    input  logic [1:0]          cpu_req_size,
    input  logic                cpu_req_unsigned,
    input  logic [ADDR_W-1:0]   cpu_req_addr,
    input  logic [XLEN-1:0]     cpu_req_wdata,
    output logic                cpu_busy,
    output logic                cpu_done,
    output logic                cpu_fault,
    output logic [CAUSE_W-1:0]  cpu_cause,
    output logic [ADDR_W-1:0]   cpu_tval,
    output logic                cpu_load_wr,
    output logic [XLEN-1:0]     cpu_load_data,
    output logic                bus_req_valid,
    input  logic                bus_req_ready,
    output logic [ADDR_W-1:0]   bus_req_addr,
    output logic                bus_req_we,
    output logic [1:0]          bus_req_size,
    output logic [XLEN-1:0]     bus_req_wdata,
    output logic [LANES-1:0]    bus_req_wstrb,
    output logic [AMO_W-1:0]    bus_req_amo,
    input  logic                bus_rsp_valid,
    output logic                bus_rsp_ready,
    input  logic [XLEN-1:0]     bus_rsp_rdata,
    input  logic                bus_rsp_err
);
    dau_state_e        state;
    acc_kind_t         r_kind;
    logic [ADDR_W-1:0] r_addr;
    logic [XLEN-1:0]   r_wdata;
    logic              in_misaligned;
    logic              accept;
    logic              rsp_fire;
    logic [XLEN-1:0]   load_value;
    acc_kind_t         in_kind;

    assign in_kind  = '{store: cpu_req_store,
                        size:  acc_size_e'(cpu_req_size),
                        unsgn: cpu_req_unsigned};
    assign cpu_req_ready = (state == ST_IDLE);
    assign cpu_busy      = (state != ST_IDLE);
    assign accept        = cpu_req_valid && cpu_req_ready;
    assign rsp_fire      = bus_rsp_valid && bus_rsp_ready;

    dau_align_check u_align (
        .size       (in_kind.size),
        .off        (cpu_req_addr[OFF_W-1:0]),
        .misaligned (in_misaligned)
    );

    dau_store_pack u_pack (
        .store (r_kind.store),
        .size  (r_kind.size),
        .off   (r_addr[OFF_W-1:0]),
        .src   (r_wdata),
        .strb  (bus_req_wstrb),
        .lanes (bus_req_wdata)
    );

    dau_load_extract u_extract (
        .rdata  (bus_rsp_rdata),
        .size   (r_kind.size),
        .unsgn  (r_kind.unsgn),
        .off    (r_addr[OFF_W-1:0]),
        .result (load_value)
    );

    assign bus_req_valid = (state == ST_ISSUE);
    assign bus_req_addr  = r_addr;
    assign bus_req_we    = r_kind.store;
    assign bus_req_size  = r_kind.size;
    assign bus_req_amo   = '0;
    assign bus_rsp_ready = (state == ST_WAIT);

    // Sequence one transaction: capture, issue, await response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            r_kind  <= '0;
            r_addr  <= '0;
            r_wdata <= '0;
        end else begin
            case (state)
                ST_IDLE: if (accept) begin
                    r_kind  <= in_kind;
                    r_addr  <= cpu_req_addr;
                    r_wdata <= cpu_req_wdata;
                    if (!in_misaligned) state <= ST_ISSUE;
                end
                ST_ISSUE: if (bus_req_ready) state <= ST_WAIT;
                ST_WAIT:  if (rsp_fire)      state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Register the completion pulse, its cause code and the load result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_done      <= 1'b0;
            cpu_fault     <= 1'b0;
            cpu_load_wr   <= 1'b0;
            cpu_cause     <= '0;
            cpu_tval      <= '0;
            cpu_load_data <= '0;
        end else begin
            cpu_done    <= 1'b0;
            cpu_fault   <= 1'b0;
            cpu_load_wr <= 1'b0;
            if (accept && in_misaligned) begin
                cpu_done  <= 1'b1;
                cpu_fault <= 1'b1;
                cpu_cause <= cpu_req_store ? CAUSE_ST_MISALIGN : CAUSE_LD_MISALIGN;
                cpu_tval  <= cpu_req_addr;
            end else if (rsp_fire) begin
                cpu_done <= 1'b1;
                if (bus_rsp_err) begin
                    cpu_fault <= 1'b1;
                    cpu_cause <= r_kind.store ? CAUSE_ST_FAULT : CAUSE_LD_FAULT;
                    cpu_tval  <= r_addr;
                end else begin
                    cpu_cause <= '0;
                    cpu_tval  <= '0;
                    if (!r_kind.store) begin
                        cpu_load_wr   <= 1'b1;
                        cpu_load_data <= load_value;
                    end
                end
            end
        end
    end

    // R1: no misaligned or reserved-size beat ever reaches the bus.
    assert_no_misaligned_issue_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_valid |-> (bus_req_size != 2'b11)
                       && !(bus_req_size == 2'b01 && bus_req_addr[0])
                       && !(bus_req_size == 2'b10 && bus_req_addr[1:0] != 2'b00));

    // R2: every fault carries one of the four access cause codes.
    assert_cause_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_done && cpu_fault) |-> (cpu_cause >= CAUSE_LD_MISALIGN
                                     && cpu_cause <= CAUSE_ST_FAULT));

    // R3: strobe population matches the size of a write beat.
    assert_strobe_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_valid && bus_req_we) |->
            ($countones(bus_req_wstrb) ==
             ((bus_req_size == 2'b00) ? 1 : (bus_req_size == 2'b01) ? 2 : 4)));

    // R4: a read beat carries no strobes and no data.
    assert_read_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_valid && !bus_req_we) |-> (bus_req_wstrb == '0 && bus_req_wdata == '0));

    // R6: a fault never writes a load result.
    assert_fault_no_wb_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_fault |-> (cpu_done && !cpu_load_wr));

    // R7: a stalled request holds its payload.
    assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_valid && !bus_req_ready) |=>
            (bus_req_valid && $stable(bus_req_addr) && $stable(bus_req_wdata)
             && $stable(bus_req_wstrb) && $stable(bus_req_we)));

    // R10: a response handshake is followed by a completion pulse.
    assert_done_after_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rsp_valid && bus_rsp_ready) |=> cpu_done);
endmodule

// File: tb/test_dmem_access_unit.sv
`timescale 1ns/1ps
module test_dmem_access_unit;
    localparam int AW = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req_valid = 1'b0;
    logic        cpu_req_ready;
    logic        cpu_req_store = 1'b0;
    logic [1:0]  cpu_req_size = 2'b00;
    logic        cpu_req_unsigned = 1'b0;
    logic [AW-1:0] cpu_req_addr = '0;
    logic [31:0] cpu_req_wdata = '0;
    logic        cpu_busy, cpu_done, cpu_fault, cpu_load_wr;
    logic [4:0]  cpu_cause;
    logic [AW-1:0] cpu_tval;
    logic [31:0] cpu_load_data;
    logic        bus_req_valid;
    logic        bus_req_ready = 1'b0;
    logic [AW-1:0] bus_req_addr;
    logic        bus_req_we;
    logic [1:0]  bus_req_size;
    logic [31:0] bus_req_wdata;
    logic [3:0]  bus_req_wstrb;
    logic [3:0]  bus_req_amo;
    logic        bus_rsp_valid = 1'b0;
    logic        bus_rsp_ready;
    logic [31:0] bus_rsp_rdata = '0;
    logic        bus_rsp_err = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    dmem_access_unit #(.ADDR_W(AW)) i_dmem_access_unit (
        .clk, .rst_n,
        .cpu_req_valid, .cpu_req_ready, .cpu_req_store, .cpu_req_size,
        .cpu_req_unsigned, .cpu_req_addr, .cpu_req_wdata,
        .cpu_busy, .cpu_done, .cpu_fault, .cpu_cause, .cpu_tval,
        .cpu_load_wr, .cpu_load_data,
        .bus_req_valid, .bus_req_ready, .bus_req_addr, .bus_req_we,
        .bus_req_size, .bus_req_wdata, .bus_req_wstrb, .bus_req_amo,
        .bus_rsp_valid, .bus_rsp_ready, .bus_rsp_rdata, .bus_rsp_err
    );

    typedef struct {
        logic        fault;
        logic [4:0]  cause;
        logic [31:0] tval;
        logic        load_wr;
        logic [31:0] data;
        string       tag;
    } exp_done_t;

    typedef struct {
        logic [31:0] addr;
        logic        we;
        logic [1:0]  size;
        logic [31:0] wdata;
        logic [3:0]  wstrb;
        logic [31:0] rdata;
        logic        err;
        int          req_wait;
        int          rsp_wait;
    } exp_bus_t;

    exp_done_t done_q[$];
    exp_bus_t  bus_q[$];
    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference model written from the requirements.
    function automatic logic ref_mis(input logic [1:0] sz, input logic [1:0] a);
        case (sz)
            2'b00:   return 1'b0;
            2'b01:   return a[0];
            2'b10:   return a != 2'b00;
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic [3:0] ref_strb(input logic [1:0] sz, input logic [1:0] a);
        case (sz)
            2'b00:   return 4'b0001 << a;
            2'b01:   return 4'b0011 << a;
            default: return 4'b1111;
        endcase
    endfunction

    function automatic logic [31:0] ref_wdata(input logic [1:0] sz, input logic [1:0] a,
                                              input logic [31:0] d);
        logic [31:0] m;
        m = (sz == 2'b00) ? {24'h0, d[7:0]} : (sz == 2'b01) ? {16'h0, d[15:0]} : d;
        return m << (8 * a);
    endfunction

    function automatic logic [31:0] ref_load(input logic [1:0] sz, input logic uns,
                                             input logic [1:0] a, input logic [31:0] rd);
        logic [7:0]  b;
        logic [15:0] h;
        b = rd[8*a +: 8];
        h = (a == 2'b00) ? rd[15:0] : rd[31:16];
        case (sz)
            2'b00:   return uns ? {24'h0, b} : {{24{b[7]}}, b};
            2'b01:   return uns ? {16'h0, h} : {{16{h[15]}}, h};
            default: return rd;
        endcase
    endfunction

    // Driver: pushes expectations, then presents the access.
    task automatic op(input logic st, input logic [1:0] sz, input logic uns,
                      input logic [31:0] a, input logic [31:0] wd, input logic [31:0] rd,
                      input logic err, input int rw, input int pw, input string tag);
        exp_done_t e;
        exp_bus_t  b;
        logic      mis;
        mis = ref_mis(sz, a[1:0]);
        e.tag = tag; e.load_wr = 1'b0; e.data = '0; e.tval = a; e.fault = 1'b1;
        if (mis)      e.cause = st ? 5'd6 : 5'd4;
        else if (err) e.cause = st ? 5'd7 : 5'd5;
        else begin
            e.fault = 1'b0; e.cause = '0;
            e.load_wr = !st;
            e.data = st ? '0 : ref_load(sz, uns, a[1:0], rd);
        end
        while (!cpu_req_ready) @(negedge clk);
        if (!mis) begin
            b.addr = a; b.we = st; b.size = sz;
            b.wdata = st ? ref_wdata(sz, a[1:0], wd) : '0;
            b.wstrb = st ? ref_strb(sz, a[1:0]) : 4'b0000;
            b.rdata = rd; b.err = err; b.req_wait = rw; b.rsp_wait = pw;
            bus_q.push_back(b);
        end
        done_q.push_back(e);
        cpu_req_valid = 1'b1; cpu_req_store = st; cpu_req_size = sz;
        cpu_req_unsigned = uns; cpu_req_addr = a; cpu_req_wdata = wd;
        @(negedge clk);
        cpu_req_valid = 1'b0;
        chk(cpu_busy == !mis, {"R8 busy after accept ", tag}, 32'(cpu_busy), 32'(!mis));
        chk(cpu_req_ready == mis, {"R8 ready after accept ", tag},
            32'(cpu_req_ready), 32'(mis));
    endtask

    // Bus model and request monitor.
    initial begin
        exp_bus_t b;
        forever begin
            @(negedge clk);
            if (rst_n && bus_req_valid) begin
                if (bus_q.size() == 0) begin
                    chk(1'b0, "R1 unexpected bus request", bus_req_addr, 32'h0);
                    b = '{default: '0};
                end else begin
                    b = bus_q.pop_front();
                    chk(bus_req_addr == b.addr, "R4 addr", bus_req_addr, b.addr);
                    chk(bus_req_we == b.we, "R4 we", 32'(bus_req_we), 32'(b.we));
                    chk(bus_req_size == b.size, "R4 size", 32'(bus_req_size), 32'(b.size));
                    chk(bus_req_wdata == b.wdata, "R3 wdata", bus_req_wdata, b.wdata);
                    chk(bus_req_wstrb == b.wstrb, "R3 wstrb", 32'(bus_req_wstrb), 32'(b.wstrb));
                    chk(bus_req_amo == 4'h0, "R4 amo", 32'(bus_req_amo), 32'h0);
                end
                for (int k = 0; k < b.req_wait; k++) begin
                    chk(bus_rsp_ready == 1'b0, "R7 rsp_ready before accept",
                        32'(bus_rsp_ready), 32'h0);
                    @(negedge clk);
                    chk(bus_req_valid && bus_req_addr == b.addr, "R7 request held",
                        bus_req_addr, b.addr);
                end
                bus_req_ready = 1'b1;
                @(negedge clk);
                bus_req_ready = 1'b0;
                for (int k = 0; k < b.rsp_wait; k++) @(negedge clk);
                chk(bus_rsp_ready == 1'b1, "R7 rsp_ready after accept",
                    32'(bus_rsp_ready), 32'h1);
                bus_rsp_valid = 1'b1; bus_rsp_rdata = b.rdata; bus_rsp_err = b.err;
                @(negedge clk);
                bus_rsp_valid = 1'b0; bus_rsp_err = 1'b0;
            end
        end
    end

    // Completion monitor: pops and compares each done pulse.
    initial begin
        exp_done_t e;
        forever begin
            @(negedge clk);
            if (rst_n && cpu_done) begin
                if (done_q.size() == 0) begin
                    chk(1'b0, "R10 spurious done", 32'h1, 32'h0);
                end else begin
                    e = done_q.pop_front();
                    chk(cpu_fault == e.fault, {e.tag, " fault"}, 32'(cpu_fault), 32'(e.fault));
                    chk(cpu_load_wr == e.load_wr, {e.tag, " load_wr"},
                        32'(cpu_load_wr), 32'(e.load_wr));
                    if (e.fault) begin
                        chk(cpu_cause == e.cause, {e.tag, " cause"}, 32'(cpu_cause), 32'(e.cause));
                        chk(cpu_tval == e.tval, {e.tag, " tval"}, cpu_tval, e.tval);
                    end
                    if (e.load_wr)
                        chk(cpu_load_data == e.data, {e.tag, " data"}, cpu_load_data, e.data);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            chk(1'b0, "watchdog expired", 32'h0, 32'h1);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    localparam logic [31:0] RD = 32'h81F2_7F93;

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(cpu_req_ready == 1'b1, "R9 ready in reset", 32'(cpu_req_ready), 32'h1);
        chk(cpu_busy == 1'b0, "R9 busy in reset", 32'(cpu_busy), 32'h0);
        chk(bus_req_valid == 1'b0, "R9 bus valid in reset", 32'(bus_req_valid), 32'h0);
        chk(cpu_done == 1'b0, "R9 done in reset", 32'(cpu_done), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        op(0, 2'b10, 0, 32'h8000_0010, 0, 32'h1234_5678, 0, 0, 0, "R5 lw");
        for (int o = 0; o < 4; o++)
            op(0, 2'b00, 0, 32'h8000_0020 + o, 0, RD, 0, 0, 0, "R5 lb");
        for (int o = 0; o < 4; o++)
            op(0, 2'b00, 1, 32'h8000_0030 + o, 0, RD, 0, 1, 0, "R5 lbu");
        op(0, 2'b01, 0, 32'h8000_0040, 0, RD, 0, 0, 1, "R5 lh off0");
        op(0, 2'b01, 0, 32'h8000_0042, 0, RD, 0, 0, 0, "R5 lh off2");
        op(0, 2'b01, 1, 32'h8000_0046, 0, RD, 0, 0, 0, "R5 lhu off2");
        for (int o = 0; o < 4; o++)
            op(1, 2'b00, 0, 32'h8000_0050 + o, 32'h1234_56A5, 0, 0, 0, 0, "R10 sb");
        op(1, 2'b01, 0, 32'h8000_0060, 32'hCAFE_BEEF, 0, 0, 0, 0, "R10 sh off0");
        op(1, 2'b01, 0, 32'h8000_0062, 32'hCAFE_BEEF, 0, 0, 1, 2, "R10 sh off2");
        op(1, 2'b10, 0, 32'h8000_0064, 32'hDEAD_BEEF, 0, 0, 2, 1, "R10 sw");
        // R1/R2: misaligned accesses, no bus beat expected
        op(0, 2'b01, 0, 32'h9000_0001, 0, 0, 0, 0, 0, "R2 lh off1");
        op(0, 2'b01, 0, 32'h9000_0003, 0, 0, 0, 0, 0, "R2 lh off3");
        op(0, 2'b10, 0, 32'h9000_0005, 0, 0, 0, 0, 0, "R2 lw off1");
        op(0, 2'b10, 0, 32'h9000_0006, 0, 0, 0, 0, 0, "R2 lw off2");
        op(0, 2'b10, 0, 32'hF000_0007, 0, 0, 0, 0, 0, "R2 lw off3");
        op(1, 2'b01, 0, 32'h9000_0009, 32'h1, 0, 0, 0, 0, "R2 sh off1");
        op(1, 2'b10, 0, 32'h9000_000A, 32'h1, 0, 0, 0, 0, "R2 sw off2");
        op(0, 2'b11, 0, 32'h9000_0010, 0, 0, 0, 0, 0, "R1 rsvd load");
        op(1, 2'b11, 0, 32'h9000_0014, 32'h1, 0, 0, 0, 0, "R1 rsvd store");
        // R6: bus errors
        op(0, 2'b10, 0, 32'hC000_0100, 0, RD, 1, 0, 0, "R6 lw err");
        op(1, 2'b00, 0, 32'hC000_0101, 32'h55, 0, 1, 2, 3, "R6 sb err");
        op(0, 2'b01, 1, 32'hC000_0102, 0, RD, 1, 1, 1, "R6 lhu err");
        // R7/R8: long stalls, misaligned directly before an aligned access
        op(0, 2'b10, 0, 32'h8000_0100, 0, 32'hA5A5_0F0F, 0, 3, 4, "R7 lw stall");
        op(1, 2'b10, 0, 32'h8000_0103, 32'h7, 0, 0, 0, 0, "R8 sw mis");
        op(0, 2'b00, 0, 32'h8000_0107, 0, 32'h7F00_0000, 0, 0, 0, "R8 lb after fault");

        for (int t = 0; t < 50 && (done_q.size() != 0 || bus_q.size() != 0); t++)
            @(negedge clk);
        chk(done_q.size() == 0, "R10 completions outstanding", 32'(done_q.size()), 32'h0);
        chk(bus_q.size() == 0, "R1 bus beats outstanding", 32'(bus_q.size()), 32'h0);
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule